// File: doc/BRIEF.md
# Heartbeat Status Message Serializer

This block assembles a fixed-layout status message and shifts it out on a single data line, one bit per clock-enable pulse. Each message packs a 4-bit rolling sequence number, a 2-bit system power state code, two 8-bit message register values and an 8-bit watchdog status value into a 30-bit frame. The sequence number is kept inside the block and advances once per completed message.

A host raises the send request while the block is idle. All field values are frozen into a shift register on that cycle. The block then drives the frame out MSB first, starting with the sequence field, on each cycle where the bit-enable input is high. The busy flag stays high until the last bit has gone out. Framing, the physical link and register programming sit outside this block.

Top module: `hb_serializer`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), busy and ser_valid are 0, and the first message sent carries sequence value 0000.
- R2: The sequence number increases by one each time a message completes. It wraps from 1111 to 0000, so the 17th message carries 0000 again.
- R3: A message is 30 bits sent in this order: sequence[3:0], power state[1:0], msg1[7:0], msg2[7:0], wd_stat[7:0]. Every field is sent MSB first. The power code is passed through unchanged (00 = G0, 01 = G1, 10 = G2, 11 = pre-boot).
- R4: All field values are captured on the cycle the request is accepted. Changes to pwr_state, msg1, msg2 or wd_stat while busy do not alter the message in flight.
- R5: A send request that arrives while busy is ignored. It produces no extra bits and does not advance the sequence number.
- R6: Exactly one bit is delivered per bit_en pulse while busy. ser_valid is high only in cycles with bit_en high during a message, and a message yields exactly 30 valid bits.
- R7: busy rises on the clock edge that accepts an idle send request. It falls on the edge of the 30th bit pulse, after which a new request is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Bit-rate enable pulse; one bit is shifted per pulse |
| send_req | input | 1 | Request to start a message (accepted only when idle) |
| pwr_state | input | 2 | System power state code |
| msg1 | input | 8 | First message register value |
| msg2 | input | 8 | Second message register value |
| wd_stat | input | 8 | Watchdog status register value |
| ser_data | output | 1 | Serial data, valid when ser_valid is high |
| ser_valid | output | 1 | Strobe marking a delivered bit |
| busy | output | 1 | A message is being sent |

## Verification
The bench builds the block with its default widths: a 4-bit sequence, a 2-bit power code and 8-bit registers, giving a 30-bit frame. With a 4-bit sequence, sixteen messages are enough to reach the wrap from 1111 to 0000, so the bench sends seventeen messages within a short run. It varies the bit-enable spacing (every cycle, every second and every third cycle) to show that the output depends on pulses and not on clock cycles. It also changes the inputs and repeats the send request mid-message to exercise the capture and ignore rules.

// File: rtl/hb_pkg.sv
// Package: shared widths and power-state codes for the heartbeat serializer.
// Assumes: field widths are fixed by the message layout; the top may override.
package hb_pkg;
    localparam int SEQ_W_DEF = 4;
    localparam int PWR_W_DEF = 2;
    localparam int REG_W_DEF = 8;

    // Power state encoding carried in the 2-bit field
    typedef enum logic [1:0] {
        PWR_WORKING  = 2'b00,
        PWR_SLEEP    = 2'b01,
        PWR_SOFT_OFF = 2'b10,
        PWR_PREBOOT  = 2'b11
    } pwr_code_e;

    // Total frame length for a given set of field widths
    function automatic int frame_len(input int seq_w, input int pwr_w, input int reg_w);
        return seq_w + pwr_w + 3 * reg_w;
    endfunction
endpackage

// File: rtl/hb_seq_counter.sv
// Module: rolling message sequence counter.
// Does: holds the sequence number for the next message; advances by one on
//       each completed message and wraps naturally at its width.
// Assumes: msg_done is a single-cycle pulse from the shifter.
module hb_seq_counter #(
    parameter int SEQ_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             msg_done,
    output logic [SEQ_W-1:0] seq
);
    // Purpose: clear on reset, step on message completion
    always_ff @(posedge clk) begin
        if (!rst_n)
            seq <= '0;
        else if (msg_done)
            seq <= seq + 1'b1;
    end

    // R2
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_done |=> seq == SEQ_W'($past(seq) + 1'b1));

    // R5
    seq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !msg_done |=> $stable(seq));
endmodule

// File: rtl/hb_frame_packer.sv
// Module: message frame assembler.
// Does: concatenates the fields into one vector with the sequence field in the
//       top bits, then power state, msg1, msg2 and watchdog status.
// Assumes: the vector is shifted out from its MSB, so field order and MSB-first
//          order both follow from this layout.
module hb_frame_packer #(
    parameter int SEQ_W = 4,
    parameter int PWR_W = 2,
    parameter int REG_W = 8,
    localparam int LEN  = SEQ_W + PWR_W + 3 * REG_W
) (
    input  logic [SEQ_W-1:0] seq,
    input  logic [PWR_W-1:0] pwr_state,
    input  logic [REG_W-1:0] msg1,
    input  logic [REG_W-1:0] msg2,
    input  logic [REG_W-1:0] wd_stat,
    output logic [LEN-1:0]   frame
);
    // Purpose: fixed field layout, first-sent field in the top bits
    always_comb begin
        frame = {seq, pwr_state, msg1, msg2, wd_stat};
    end
endmodule

// File: rtl/hb_shifter.sv
// Module: frame shift register with bit counter.
// Does: loads the frame on an accepted request, shifts it out MSB first one
//       bit per bit_en pulse, and flags completion on the last bit.
// Assumes: LEN >= 2; requests while busy are dropped here.
module hb_shifter #(
    parameter int LEN  = 30,
    localparam int CW  = $clog2(LEN),
    localparam logic [CW-1:0] LAST = CW'(LEN - 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           send_req,
    input  logic [LEN-1:0] frame,
    input  logic           bit_en,
    output logic           ser_data,
    output logic           ser_valid,
    output logic           busy,
    output logic           msg_done
);
    logic [LEN-1:0] shreg;
    logic [CW-1:0]  bit_cnt;
    logic           busy_q;
    logic           accept;
    logic           step;

    // Purpose: decode request acceptance and shift steps
    always_comb begin
        accept   = send_req && !busy_q;
        step     = busy_q && bit_en;
        msg_done = step && (bit_cnt == LAST);
    end

    // Purpose: load, shift and count the frame bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_cnt <= '0;
            busy_q  <= 1'b0;
        end else if (accept) begin
            shreg   <= frame;
            bit_cnt <= '0;
            busy_q  <= 1'b1;
        end else if (step) begin
            shreg <= {shreg[LEN-2:0], 1'b0};
            if (bit_cnt == LAST) begin
                bit_cnt <= '0;
                busy_q  <= 1'b0;
            end else begin
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    // Purpose: drive the serial outputs from the register head
    always_comb begin
        ser_data  = shreg[LEN-1];
        ser_valid = step;
        busy      = busy_q;
    end

    // R7
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> $past(send_req));

    // R7
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> $past(bit_en) && $past(bit_cnt) == LAST);

    // R6
    hold_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && !bit_en |=> $stable(shreg) && $stable(bit_cnt));

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= LAST);

    // R5
    idle_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> bit_cnt == '0);
endmodule

// File: rtl/hb_serializer.sv
// Module: heartbeat status message serializer (top).
// Does: joins the sequence counter, frame packer and shifter. A request while
//       idle freezes the current field values and sends them MSB first.
// Assumes: bit_en is synchronous to clk; inputs need only be valid on the
//          cycle a request is accepted.
module hb_serializer #(
    parameter int SEQ_W = hb_pkg::SEQ_W_DEF,
    parameter int PWR_W = hb_pkg::PWR_W_DEF,
    parameter int REG_W = hb_pkg::REG_W_DEF,
    localparam int LEN  = hb_pkg::frame_len(SEQ_W, PWR_W, REG_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             send_req,
    input  logic [PWR_W-1:0] pwr_state,
    input  logic [REG_W-1:0] msg1,
    input  logic [REG_W-1:0] msg2,
    input  logic [REG_W-1:0] wd_stat,
    output logic             ser_data,
    output logic             ser_valid,
    output logic             busy
);
    logic [SEQ_W-1:0] seq;
    logic [LEN-1:0]   frame;
    logic             msg_done;

    hb_seq_counter #(.SEQ_W(SEQ_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .msg_done (msg_done),
        .seq      (seq)
    );

    hb_frame_packer #(.SEQ_W(SEQ_W), .PWR_W(PWR_W), .REG_W(REG_W)) u_pack (
        .seq       (seq),
        .pwr_state (pwr_state),
        .msg1      (msg1),
        .msg2      (msg2),
        .wd_stat   (wd_stat),
        .frame     (frame)
    );

    hb_shifter #(.LEN(LEN)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .send_req  (send_req),
        .frame     (frame),
        .bit_en    (bit_en),
        .ser_data  (ser_data),
        .ser_valid (ser_valid),
        .busy      (busy),
        .msg_done  (msg_done)
    );

    // R6
    valid_in_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_valid |-> busy);
endmodule

// File: tb/tb_hb_serializer.sv
// Bench: scoreboard for the heartbeat serializer. The driver pushes expected
// bits, and the monitor pops and compares them on each delivered bit.
module tb_hb_serializer;
    import hb_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       send_req = 1'b0;
    logic [1:0] pwr_state = '0;
    logic [7:0] msg1 = '0, msg2 = '0, wd_stat = '0;
    logic       ser_data, ser_valid, busy;

    typedef struct { logic b; string tag; } exp_t;
    exp_t exp_q[$];

    int checks = 0;
    int errors = 0;
    int valid_seen = 0;
    int msgs_sent = 0;
    int en_div = 1;
    int cyc = 0;
    logic [3:0] tb_seq = 4'h0;
    bit finished = 0;

    hb_serializer dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .send_req(send_req),
        .pwr_state(pwr_state), .msg1(msg1), .msg2(msg2), .wd_stat(wd_stat),
        .ser_data(ser_data), .ser_valid(ser_valid), .busy(busy)
    );

    always #10 clk = ~clk;

    // Bit-enable generator, driven 2 ns after the rising edge
    always @(posedge clk) begin
        cyc <= cyc + 1;
        #2 bit_en = rst_n && ((cyc % en_div) == 0);
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Monitor: compare each delivered bit against the scoreboard
    always @(negedge clk) begin
        if (rst_n && ser_valid && !finished) begin
            exp_t e;
            valid_seen++;
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R5 unexpected bit actual=%0b expected=none", ser_data);
            end else begin
                e = exp_q.pop_front();
                if (ser_data !== e.b) begin
                    errors++;
                    $display("FAIL %s bit actual=%0b expected=%0b", e.tag, ser_data, e.b);
                end
            end
        end
    end

    task automatic push_field(input logic [7:0] v, input int w, input string tag);
        for (int i = w - 1; i >= 0; i--) begin
            exp_t e;
            e.b = v[i];
            e.tag = tag;
            exp_q.push_back(e);
        end
    endtask

    // Driver: send one message, optionally disturbing inputs mid-flight
    task automatic send_msg(input logic [1:0] p, input logic [7:0] a, input logic [7:0] b,
                            input logic [7:0] w, input bit disturb);
        while (busy) @(negedge clk);
        @(posedge clk); #2;
        send_req = 1'b1; pwr_state = p; msg1 = a; msg2 = b; wd_stat = w;
        push_field({4'h0, tb_seq}, 4, "R2");     // R1 gives 0000 for the first
        push_field({6'h0, p}, 2, disturb ? "R4" : "R3");
        push_field(a, 8, disturb ? "R4" : "R3");
        push_field(b, 8, disturb ? "R4" : "R3");
        push_field(w, 8, disturb ? "R4" : "R3");
        @(posedge clk); #2;
        send_req = 1'b0;
        @(negedge clk);
        check("R7 busy after accept", {31'b0, busy}, 32'd1);
        if (disturb) begin
            repeat (3) @(posedge clk);
            #2;
            pwr_state = ~p; msg1 = ~a; msg2 = ~b; wd_stat = ~w;  // R4
            send_req = 1'b1;                                       // R5
            @(posedge clk); #2;
            send_req = 1'b0;
        end
        while (busy) @(negedge clk);
        check("R6 all bits delivered", exp_q.size(), 32'd0);
        check("R7 busy low after last bit", {31'b0, busy}, 32'd0);
        tb_seq = tb_seq + 1'b1;
        msgs_sent++;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 busy at reset", {31'b0, busy}, 32'd0);
        check("R1 valid at reset", {31'b0, ser_valid}, 32'd0);
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 idle after reset", {30'b0, busy, ser_valid}, 32'd0);

        en_div = 1;
        send_msg(PWR_WORKING, 8'hA5, 8'h3C, 8'h81, 1'b0);
        en_div = 3;
        send_msg(PWR_SLEEP, 8'h0F, 8'hF0, 8'h5A, 1'b1);
        en_div = 2;
        send_msg(PWR_SOFT_OFF, 8'h80, 8'h01, 8'hFF, 1'b0);
        send_msg(PWR_PREBOOT, 8'h12, 8'h34, 8'h56, 1'b1);
        en_div = 1;
        for (int k = 4; k < 17; k++)
            send_msg(pwr_code_e'(k[1:0]), 8'(k * 7), 8'(k * 13), 8'(8'hC3 ^ k), 1'b0);
        check("R2 wrapped expectation", {28'b0, tb_seq}, 32'd1);
        check("R6 total bit count", valid_seen, msgs_sent * 30);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        #(20 * 150000);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule